// File: doc/BRIEF.md
# Registered DIMM Reset and Self-Refresh Sequencer

This block sits on the controller side of a registered DDR memory module and owns the module's asynchronous register reset, its clock-enable, the module clock gate and the command and address pins during the two periods when no SDRAM engine may use them.

After power-up it keeps the register reset low and waits for the input clock to be reported stable. It then waits out the PLL settling interval and the SDRAM clock-stability interval, holding CKE low and parking the command pins on a defined idle command. Next it releases the register reset and holds every pin still for the register activation time. Only then does it pulse a start strobe to the external initialization engine and hand the pins over to that engine.

On request in the ready state it enters self-refresh. It sends the self-refresh command for one cycle and spends one more cycle covering the pipeline stage that the module register adds. It then pulls the register reset low, waits the register deactivate time and finally gates the module clocks off. All intervals are parameters counted in controller clock cycles.

Top module: `dimm_pwr_seq`

## Requirements
- R1: A cycle sampled with `rstN` low puts the sequencer in IDLE_RESET on the next cycle, with `regRstN`=0, `cke`=0, `clkEn`=1 and `ready`, `initStart` and `reqErr` all 0.
- R2: IDLE_RESET is held for as long as `clkStable` is low. The cycle after `clkStable` is sampled high the state is WAIT_PLL.
- R3: WAIT_PLL lasts exactly PLL_CYC cycles and WAIT_SDRAM then lasts exactly SDRAM_CYC cycles. `regRstN` stays 0 in both.
- R4: In IDLE_RESET, WAIT_PLL, WAIT_SDRAM and ACTIVATE, `cke` is 0 and `addrOut` is 0. The command pins {csN,rasN,casN,weN} read 4'b1111 (deselect) when IDLE_ALL_LOW=0 and 4'b0000 when IDLE_ALL_LOW=1.
- R5: ACTIVATE lasts exactly ACT_CYC cycles with `regRstN`=1. `cke`, the command pins and `addrOut` do not change during it.
- R6: `initStart` is 1 only in the first READY cycle. `ready` is 1 in every READY cycle and in no other state.
- R7: In READY, `cke`, {csN,rasN,casN,weN} and `addrOut` equal `engCke`, `engCmd` and `engAddr` as sampled at the previous clock edge.
- R8: When `srReq` is sampled high in READY, the next cycle is SR_CMD. In SR_CMD, `cke`=0, {csN,rasN,casN,weN}=4'b0001, `addrOut`=0 and `regRstN`=1, and the state lasts exactly one cycle.
- R9: SR_PIPE follows SR_CMD for one cycle with `regRstN`=1, `cke`=0 and the idle command. `regRstN` goes low in the next cycle, SR_RESET.
- R10: From SR_RESET on, `cke`, the command pins and `addrOut` are all 0. `clkEn` falls exactly INACT_CYC+1 cycles after `regRstN` falls, on entry to SR_CLK_OFF, and that state holds until `rstN` is applied.
- R11: `srReq` sampled high in any state other than READY does not change the state. It produces a one-cycle `reqErr` pulse in the following cycle.
- R12: `seqState` encodes IDLE_RESET=0, WAIT_PLL=1, WAIT_SDRAM=2, ACTIVATE=3, READY=4, SR_CMD=5, SR_PIPE=6, SR_RESET=7, SR_WAIT_INACT=8, SR_CLK_OFF=9. No other value appears.
- R13: Applying `rstN` in any state, including READY and SR_CLK_OFF, returns the sequencer to IDLE_RESET on the next cycle with the R1 output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Synchronous active-low controller reset |
| clkStable | input | 1 | Input clock to the module is stable |
| srReq | input | 1 | Request to enter self-refresh |
| engCke | input | 1 | Clock-enable from the initialization/command engine |
| engCmd | input | 4 | Engine command {csN,rasN,casN,weN} |
| engAddr | input | ADDR_W | Engine address |
| regRstN | output | 1 | Asynchronous reset to the module register, active low |
| cke | output | 1 | Clock-enable to the module |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addrOut | output | ADDR_W | Address to the module |
| clkEn | output | 1 | Module clock gate, 0 turns the module clocks off |
| initStart | output | 1 | One-cycle start strobe to the initialization engine |
| ready | output | 1 | Sequencer has handed the pins to the engine |
| reqErr | output | 1 | One-cycle pulse for a rejected self-refresh request |
| seqState | output | 4 | Current state, encoded as in R12 |

## Verification
The bench counts each interval to its last cycle and to its first cycle after. An off-by-one timer would therefore leave WAIT_PLL, WAIT_SDRAM or ACTIVATE one cycle early or late, or drop the clock gate one cycle off its INACT_CYC+1 distance from the reset fall. The self-refresh entry is checked cycle by cycle, so a design that skipped the register pipeline cycle would pull `regRstN` low one cycle after the command instead of two. A design that got the command bits wrong would show a wrong SR_CMD pattern. Requests are sent during WAIT_SDRAM and SR_CLK_OFF: a design that accepted them would move state, and one that missed the flag would show no `reqErr`. Two instances cover both idle-command variants, and the controller reset is applied from READY and from SR_CLK_OFF.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE_RESET    = 4'd0,
    ST_WAIT_PLL      = 4'd1,
    ST_WAIT_SDRAM    = 4'd2,
    ST_ACTIVATE      = 4'd3,
    ST_READY         = 4'd4,
    ST_SR_CMD        = 4'd5,
    ST_SR_PIPE       = 4'd6,
    ST_SR_RESET      = 4'd7,
    ST_SR_WAIT_INACT = 4'd8,
    ST_SR_CLK_OFF    = 4'd9
  } seq_state_e;

  // which interval the timer loads on a state entry
  typedef enum logic [1:0] {
    IVL_PLL   = 2'd0,
    IVL_SDRAM = 2'd1,
    IVL_ACT   = 2'd2,
    IVL_INACT = 2'd3
  } ivl_e;

  // how the pin registers are filled
  typedef enum logic [1:0] {
    DRV_IDLE  = 2'd0,
    DRV_PASS  = 2'd1,
    DRV_SRCMD = 2'd2,
    DRV_LOW   = 2'd3
  } drv_e;

  // strobes from control to datapath, describing the next cycle
  typedef struct packed {
    logic tmrLoad;
    ivl_e tmrSel;
    drv_e drive;
    logic rstHigh;
    logic clkOn;
    logic initPulse;
    logic readyOn;
    logic errPulse;
  } strobe_t;

  localparam logic [3:0] CMD_SELF_REFRESH = 4'b0001; // cs, ras, cas low, we high

endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkStable,
  input  logic       srReq,
  input  logic       timerDone,
  output seq_state_e stateQ,
  output strobe_t    strobe
);

  seq_state_e nextState;

  always_comb begin
    nextState = stateQ;
    case (stateQ)
      ST_IDLE_RESET:    if (clkStable) nextState = ST_WAIT_PLL;
      ST_WAIT_PLL:      if (timerDone) nextState = ST_WAIT_SDRAM;
      ST_WAIT_SDRAM:    if (timerDone) nextState = ST_ACTIVATE;
      ST_ACTIVATE:      if (timerDone) nextState = ST_READY;
      ST_READY:         if (srReq)     nextState = ST_SR_CMD;
      ST_SR_CMD:                       nextState = ST_SR_PIPE;
      ST_SR_PIPE:                      nextState = ST_SR_RESET;
      ST_SR_RESET:                     nextState = ST_SR_WAIT_INACT;
      ST_SR_WAIT_INACT: if (timerDone) nextState = ST_SR_CLK_OFF;
      ST_SR_CLK_OFF:                   nextState = ST_SR_CLK_OFF;
      default:                         nextState = ST_IDLE_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE_RESET;
    else       stateQ <= nextState;
  end

  always_comb begin
    strobe.tmrLoad = (nextState != stateQ);
    case (nextState)
      ST_WAIT_SDRAM:    strobe.tmrSel = IVL_SDRAM;
      ST_ACTIVATE:      strobe.tmrSel = IVL_ACT;
      ST_SR_WAIT_INACT: strobe.tmrSel = IVL_INACT;
      default:          strobe.tmrSel = IVL_PLL;
    endcase
    case (nextState)
      ST_READY:         strobe.drive = DRV_PASS;
      ST_SR_CMD:        strobe.drive = DRV_SRCMD;
      ST_SR_RESET,
      ST_SR_WAIT_INACT,
      ST_SR_CLK_OFF:    strobe.drive = DRV_LOW;
      default:          strobe.drive = DRV_IDLE;
    endcase
    strobe.rstHigh   = (nextState == ST_ACTIVATE) || (nextState == ST_READY) ||
                       (nextState == ST_SR_CMD)   || (nextState == ST_SR_PIPE);
    strobe.clkOn     = (nextState != ST_SR_CLK_OFF);
    strobe.initPulse = (nextState == ST_READY) && (stateQ == ST_ACTIVATE);
    strobe.readyOn   = (nextState == ST_READY);
    strobe.errPulse  = srReq && (stateQ != ST_READY);
  end

endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int CNT_W        = 14,
  parameter int PLL_CYC      = 5000,
  parameter int SDRAM_CYC    = 10000,
  parameter int ACT_CYC      = 16,
  parameter int INACT_CYC    = 16,
  parameter bit IDLE_ALL_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              engCke,
  input  logic [3:0]        engCmd,
  input  logic [ADDR_W-1:0] engAddr,
  output logic              timerDone,
  output logic              regRstN,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              clkEn,
  output logic              initStart,
  output logic              ready,
  output logic              reqErr
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;
  logic [3:0]       idleCmd;

  generate
    if (IDLE_ALL_LOW) begin : g_idle_low
      assign idleCmd = 4'b0000;
    end else begin : g_idle_nop
      assign idleCmd = 4'b1111;
    end
  endgenerate

  always_comb begin
    case (strobe.tmrSel)
      IVL_SDRAM: loadVal = CNT_W'(SDRAM_CYC - 1);
      IVL_ACT:   loadVal = CNT_W'(ACT_CYC - 1);
      IVL_INACT: loadVal = CNT_W'(INACT_CYC - 1);
      default:   loadVal = CNT_W'(PLL_CYC - 1);
    endcase
  end

  assign timerDone = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      regRstN   <= 1'b0;
      cke       <= 1'b0;
      cmd       <= idleCmd;
      addr      <= '0;
      clkEn     <= 1'b1;
      initStart <= 1'b0;
      ready     <= 1'b0;
      reqErr    <= 1'b0;
    end else begin
      if (strobe.tmrLoad)   count <= loadVal;
      else if (!timerDone)  count <= count - 1'b1;
      regRstN   <= strobe.rstHigh;
      clkEn     <= strobe.clkOn;
      initStart <= strobe.initPulse;
      ready     <= strobe.readyOn;
      reqErr    <= strobe.errPulse;
      case (strobe.drive)
        DRV_PASS: begin
          cke  <= engCke;
          cmd  <= engCmd;
          addr <= engAddr;
        end
        DRV_SRCMD: begin
          cke  <= 1'b0;
          cmd  <= CMD_SELF_REFRESH;
          addr <= '0;
        end
        DRV_LOW: begin
          cke  <= 1'b0;
          cmd  <= 4'b0000;
          addr <= '0;
        end
        default: begin
          cke  <= 1'b0;
          cmd  <= idleCmd;
          addr <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dimm_pwr_seq.sv
module dimm_pwr_seq
  import dps_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PLL_CYC      = 5000,
  parameter int SDRAM_CYC    = 10000,
  parameter int ACT_CYC      = 16,
  parameter int INACT_CYC    = 16,
  parameter bit IDLE_ALL_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkStable,
  input  logic              srReq,
  input  logic              engCke,
  input  logic [3:0]        engCmd,
  input  logic [ADDR_W-1:0] engAddr,
  output logic              regRstN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              clkEn,
  output logic              initStart,
  output logic              ready,
  output logic              reqErr,
  output logic [3:0]        seqState
);

  localparam int MAX_AB = (PLL_CYC > SDRAM_CYC) ? PLL_CYC : SDRAM_CYC;
  localparam int MAX_CD = (ACT_CYC > INACT_CYC) ? ACT_CYC : INACT_CYC;
  localparam int MAX_IV = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_IV + 1);

  seq_state_e stateQ;
  strobe_t    strobe;
  logic       timerDone;
  logic [3:0] cmd;

  dps_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkStable (clkStable),
    .srReq     (srReq),
    .timerDone (timerDone),
    .stateQ    (stateQ),
    .strobe    (strobe)
  );

  dps_datapath #(
    .ADDR_W       (ADDR_W),
    .CNT_W        (CNT_W),
    .PLL_CYC      (PLL_CYC),
    .SDRAM_CYC    (SDRAM_CYC),
    .ACT_CYC      (ACT_CYC),
    .INACT_CYC    (INACT_CYC),
    .IDLE_ALL_LOW (IDLE_ALL_LOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .engCke    (engCke),
    .engCmd    (engCmd),
    .engAddr   (engAddr),
    .timerDone (timerDone),
    .regRstN   (regRstN),
    .cke       (cke),
    .cmd       (cmd),
    .addr      (addrOut),
    .clkEn     (clkEn),
    .initStart (initStart),
    .ready     (ready),
    .reqErr    (reqErr)
  );

  assign {csN, rasN, casN, weN} = cmd;
  assign seqState = stateQ;

endmodule

// File: rtl/dps_chk.sv
module dps_chk
  import dps_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       srReq,
  input logic [3:0] seqState,
  input logic       regRstN,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       clkEn,
  input logic       initStart,
  input logic       ready,
  input logic       reqErr
);

  logic prevRstLow = 1'b0;

  always_ff @(posedge clk) begin
    prevRstLow <= !rstN;
    // R1 and R13: one cycle after a sampled reset the outputs are safe
    if (prevRstLow) begin
      p_reset_safe_r1: assert (seqState == ST_IDLE_RESET && !regRstN && !cke && clkEn && !ready)
        else $error("p_reset_safe_r1");
    end
  end

  p_prerdy_cke_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqState <= ST_ACTIVATE) |-> (!cke && !ready));

  p_act_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_ACTIVATE && $past(seqState) == ST_ACTIVATE)
      |-> $stable({regRstN, cke, csN, rasN, casN, weN}));

  p_init_in_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    initStart |-> (seqState == ST_READY && ready));

  p_init_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    initStart |=> !initStart);

  p_sr_pipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SR_CMD) |=> (seqState == ST_SR_PIPE && regRstN && !cke));

  p_rst_after_pipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_SR_PIPE) |=> !regRstN);

  p_clk_gate_late_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> (seqState == ST_SR_CLK_OFF && !regRstN));

  p_reject_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    (srReq && seqState != ST_READY) |=> reqErr);

  p_state_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    seqState <= ST_SR_CLK_OFF);

endmodule

bind dimm_pwr_seq dps_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srReq     (srReq),
  .seqState  (seqState),
  .regRstN   (regRstN),
  .cke       (cke),
  .csN       (csN),
  .rasN      (rasN),
  .casN      (casN),
  .weN       (weN),
  .clkEn     (clkEn),
  .initStart (initStart),
  .ready     (ready),
  .reqErr    (reqErr)
);

// File: tb/sim_dimm_pwr_seq.sv
module sim_dimm_pwr_seq;
  import dps_pkg::*;

  localparam int AW   = 14;
  localparam int PLL  = 12;
  localparam int SDR  = 15;
  localparam int ACT  = 6;
  localparam int INA  = 5;
  localparam int TOT  = PLL + SDR + ACT;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic          rstN, clkStable, srReq, engCke;
  logic [3:0]    engCmd;
  logic [AW-1:0] engAddr;
  logic          regRstN, cke, csN, rasN, casN, weN, clkEn, initStart, ready, reqErr;
  logic [AW-1:0] addrOut;
  logic [3:0]    seqState;
  logic          regRstN1, cke1, csN1, rasN1, casN1, weN1, clkEn1, initStart1, ready1, reqErr1;
  logic [AW-1:0] addrOut1;
  logic [3:0]    seqState1;

  dimm_pwr_seq #(.ADDR_W(AW), .PLL_CYC(PLL), .SDRAM_CYC(SDR), .ACT_CYC(ACT),
                 .INACT_CYC(INA), .IDLE_ALL_LOW(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .clkStable(clkStable), .srReq(srReq), .engCke(engCke),
    .engCmd(engCmd), .engAddr(engAddr), .regRstN(regRstN), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .addrOut(addrOut), .clkEn(clkEn),
    .initStart(initStart), .ready(ready), .reqErr(reqErr), .seqState(seqState));

  dimm_pwr_seq #(.ADDR_W(AW), .PLL_CYC(PLL), .SDRAM_CYC(SDR), .ACT_CYC(ACT),
                 .INACT_CYC(INA), .IDLE_ALL_LOW(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .clkStable(clkStable), .srReq(srReq), .engCke(engCke),
    .engCmd(engCmd), .engAddr(engAddr), .regRstN(regRstN1), .cke(cke1), .csN(csN1),
    .rasN(rasN1), .casN(casN1), .weN(weN1), .addrOut(addrOut1), .clkEn(clkEn1),
    .initStart(initStart1), .ready(ready1), .reqErr(reqErr1), .seqState(seqState1));

  typedef struct {
    int            cyc;
    logic [3:0]    st;
    logic          rr, ck, ce, rdy, ini, err, care;
    logic [3:0]    cmd;
    logic [AW-1:0] ad;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int c, logic [3:0] st, logic rr, logic ck, logic ce,
                           logic rdy, logic ini, logic err, logic care,
                           logic [3:0] cmd, logic [AW-1:0] ad, string tag);
    exp_t e;
    e.cyc = c; e.st = st; e.rr = rr; e.ck = ck; e.ce = ce; e.rdy = rdy;
    e.ini = ini; e.err = err; e.care = care; e.cmd = cmd; e.ad = ad; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor: compare scoreboard items as their cycle comes up
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      cur = sb.pop_front();
      checks++;
      if (cur.cyc < cyc) begin
        failures++;
        $display("FAIL %s: item for cycle %0d missed, got cycle %0d expected %0d",
                 cur.tag, cur.cyc, cyc, cur.cyc);
      end else if (seqState !== cur.st || regRstN !== cur.rr || cke !== cur.ck ||
                   clkEn !== cur.ce || ready !== cur.rdy || initStart !== cur.ini ||
                   reqErr !== cur.err ||
                   (cur.care && ({csN, rasN, casN, weN} !== cur.cmd || addrOut !== cur.ad))) begin
        failures++;
        $display("FAIL %s @%0d: got st=%0d rr=%b ck=%b ce=%b rdy=%b ini=%b err=%b cmd=%b ad=%h; expected st=%0d rr=%b ck=%b ce=%b rdy=%b ini=%b err=%b cmd=%b ad=%h",
                 cur.tag, cyc, seqState, regRstN, cke, clkEn, ready, initStart, reqErr,
                 {csN, rasN, casN, weN}, addrOut, cur.st, cur.rr, cur.ck, cur.ce, cur.rdy,
                 cur.ini, cur.err, cur.cmd, cur.ad);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  // driver
  initial begin
    int n, m, r, x, r2;
    rstN = 1'b0; clkStable = 1'b0; srReq = 1'b0;
    engCke = 1'b0; engCmd = 4'hF; engAddr = '0;
    @(negedge clk); @(negedge clk);
    n = cyc;
    expect_at(n + 1, ST_IDLE_RESET, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R1 reset state");
    @(negedge clk);
    rstN = 1'b1;
    n = cyc;
    for (int k = 1; k <= 5; k++)
      expect_at(n + k, ST_IDLE_RESET, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R2 hold without clock");
    wait_cyc(n + 5);
    clkStable = 1'b1;
    m = cyc;
    r = m + TOT + 1;
    expect_at(m + 1,         ST_WAIT_PLL,   0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R2/R4 enter pll wait");
    expect_at(m + PLL,       ST_WAIT_PLL,   0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R3 last pll cycle");
    expect_at(m + PLL + 1,   ST_WAIT_SDRAM, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R3 enter sdram wait");
    expect_at(m + PLL + 3,   ST_WAIT_SDRAM, 0, 0, 1, 0, 0, 1, 1, 4'hF, '0, "R11 reject in sdram wait");
    expect_at(m + PLL + 4,   ST_WAIT_SDRAM, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R11 error is one pulse");
    expect_at(m + PLL + SDR, ST_WAIT_SDRAM, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R3 last sdram cycle");
    expect_at(m + PLL + SDR + 1, ST_ACTIVATE, 1, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R5 release reset");
    expect_at(r - 1,         ST_ACTIVATE,   1, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R5 last activate cycle");
    expect_at(r,             ST_READY,      1, 0, 1, 1, 1, 0, 0, 4'hF, '0, "R6 start pulse");
    expect_at(r + 1,         ST_READY,      1, 1, 1, 1, 0, 0, 1, 4'h7, AW'(14'h01A5), "R6/R7 pass through");
    expect_at(r + 2,         ST_READY,      1, 0, 1, 1, 0, 0, 1, 4'hA, AW'(14'h002C), "R7 pass through 2");
    expect_at(r + 3,         ST_SR_CMD,     1, 0, 1, 0, 0, 0, 1, 4'b0001, '0, "R8 self-refresh command");
    expect_at(r + 4,         ST_SR_PIPE,    1, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R9 pipeline cycle");
    expect_at(r + 5,         ST_SR_RESET,   0, 0, 1, 0, 0, 0, 1, 4'h0, '0, "R9 reset falls");
    expect_at(r + 5 + INA,   ST_SR_WAIT_INACT, 0, 0, 1, 0, 0, 0, 1, 4'h0, '0, "R10 last deactivate cycle");
    expect_at(r + 6 + INA,   ST_SR_CLK_OFF, 0, 0, 0, 0, 0, 0, 1, 4'h0, '0, "R10 clocks gated");
    expect_at(r + 9 + INA,   ST_SR_CLK_OFF, 0, 0, 0, 0, 0, 1, 1, 4'h0, '0, "R11 reject in clock off");
    expect_at(r + 10 + INA,  ST_SR_CLK_OFF, 0, 0, 0, 0, 0, 0, 1, 4'h0, '0, "R10/R12 clock off holds");

    wait_cyc(m + 1);
    checks++;
    if ({csN1, rasN1, casN1, weN1} !== 4'b0000 || cke1 !== 1'b0 || addrOut1 !== '0) begin
      failures++;
      $display("FAIL R4 all-low idle: got cmd=%b ck=%b ad=%h expected cmd=0000 ck=0 ad=0",
               {csN1, rasN1, casN1, weN1}, cke1, addrOut1);
    end
    wait_cyc(m + PLL + 2);
    srReq = 1'b1;
    @(negedge clk);
    srReq = 1'b0;
    wait_cyc(r);
    engCke = 1'b1; engCmd = 4'h7; engAddr = AW'(14'h01A5);
    @(negedge clk);
    engCke = 1'b0; engCmd = 4'hA; engAddr = AW'(14'h002C);
    @(negedge clk);
    srReq = 1'b1;
    @(negedge clk);
    srReq = 1'b0;
    wait_cyc(r + 8 + INA);
    srReq = 1'b1;
    @(negedge clk);
    srReq = 1'b0;
    wait_cyc(r + 12 + INA);

    rstN = 1'b0;
    x = cyc;
    r2 = x + 1 + TOT + 1;
    expect_at(x + 1, ST_IDLE_RESET, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R13 reset from clock off");
    expect_at(x + 2, ST_WAIT_PLL,   0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R2 clock already stable");
    expect_at(r2,    ST_READY,      1, 0, 1, 1, 1, 0, 0, 4'hF, '0, "R6 second bring-up");
    expect_at(r2 + 1, ST_IDLE_RESET, 0, 0, 1, 0, 0, 0, 1, 4'hF, '0, "R13 reset from ready");
    @(negedge clk);
    rstN = 1'b1;
    wait_cyc(r2);
    rstN = 1'b0;
    wait_cyc(r2 + 3);
    report();
    $finish;
  end

endmodule